// File: doc/BRIEF.md
# Write Strobe Qualifier for a Parallel Nonvolatile Memory

This block sits between the already-synchronised control pins of a byte-wide nonvolatile memory and its write sequencer. It turns the raw chip-enable, output-enable and write-enable levels into at most one single-cycle "write accepted" pulse per genuine write cycle. The pulse comes with the address and data that the host presented during the last cycle of the strobe.

A write is accepted only when four conditions all hold. A power-up hold-off counter has expired. The digital supply-low flag is clear. The pin combination forms a write: chip enable low, write enable low and output enable high. That combination has been held for at least the minimum strobe width in clocks. Timing parameters are given in microseconds and nanoseconds together with the clock rate in MHz, and the block derives its cycle counts from them.

The control is a four-state machine. IDLE waits for a strobe that has met its minimum width. The IDLE->ARMED transition is taken when the strobe qualifies and writes are enabled. The IDLE->REJECT transition is taken when the strobe qualifies while writes are blocked. ARMED waits for the strobe to end. It takes ARMED->ISSUE when the strobe ends with the supply good, and ARMED->REJECT when the supply-low flag rises. REJECT waits out the strobe and returns through REJECT->IDLE. ISSUE drives the pulse for one cycle and then takes ISSUE->IDLE.

Top module: `wr_qualifier`

## Requirements
- R1: After reset, `wr_pulse` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: No write is accepted until `supply_low` has been 0 for POR_CYCLES = CLK_MHZ*POR_US consecutive clocks. A qualifying strobe after that point is accepted.
- R3: Any cycle with `supply_low` = 1 restarts the power-up hold-off from zero.
- R4: While `supply_low` = 1, no strobe is accepted.
- R5: The write-active condition is `ce_n`=0, `we_n`=0 and `oe_n`=1. When `oe_n` is low, `ce_n` is high or `we_n` is high, no write is recognised.
- R6: A write-active condition held for fewer than FILT = max(1, ceil(GLITCH_NS*CLK_MHZ/1000)) consecutive clocks produces no write. A condition held for FILT clocks or more qualifies.
- R7: An accepted write produces exactly one `wr_pulse`, one clock wide. It is high in the cycle that follows the first clock edge at which the write-active condition is seen deasserted.
- R8: `wr_addr` and `wr_data` take the `addr_i` and `data_i` values that were present in the last write-active cycle. They change only together with `wr_pulse` and otherwise hold their values.
- R9: If `supply_low` rises while a qualified write is waiting for its strobe to end, that write is discarded.
- R10: A strobe that qualifies while writes are blocked is never accepted, even if the block becomes enabled before the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Synchronised chip enable, active low |
| oe_n | input | 1 | Synchronised output enable, active low |
| we_n | input | 1 | Synchronised write enable, active low |
| supply_low | input | 1 | Digital flag, high when the supply is below the write threshold |
| addr_i | input | AW | Address presented by the host |
| data_i | input | DW | Data presented by the host |
| wr_pulse | output | 1 | One-cycle accepted-write event |
| wr_addr | output | AW | Address of the accepted write |
| wr_data | output | DW | Data of the accepted write |

## Verification
Two events can fall in the same cycle. A rise of `supply_low` can coincide with the wait in ARMED for the strobe to end, so the discard path and the issue path compete for that cycle. Similarly, the end of the power-up hold-off can arrive while a strobe is already qualified and sitting in REJECT. The bench provokes the first case by raising `supply_low` for one cycle in the middle of an armed strobe and then releasing the strobe, and it expects no pulse. It provokes the second case by starting a long strobe under `supply_low`, dropping the flag and holding the strobe well past the hold-off, and it again expects no pulse.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

    typedef enum logic [1:0] {
        WQ_IDLE   = 2'd0,
        WQ_ARMED  = 2'd1,
        WQ_REJECT = 2'd2,
        WQ_ISSUE  = 2'd3
    } wq_state_e;

    function automatic int unsigned wq_ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned wq_at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/wrq_por_timer.sv
module wrq_por_timer #(
    parameter int unsigned POR_CYCLES = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    output logic por_ready
);
    localparam int unsigned CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (supply_low) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign por_ready = (cnt_q == LIMIT);

    // R3: a low-supply cycle always leaves the hold-off unexpired
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !por_ready);

endmodule

// File: rtl/wrq_strobe_filter.sv
module wrq_strobe_filter #(
    parameter int unsigned FILT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_active,
    output logic hold_met
);
    localparam int unsigned RW = $clog2(FILT + 1);
    localparam logic [RW-1:0] LAST = RW'(FILT - 1);

    logic [RW-1:0] run_q;

    // write-active only when all three pins agree; any one can inhibit
    assign wr_active = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!wr_active) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hold_met = wr_active && (run_q == LAST);

    // R5: recognition implies the full pin combination
    p_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_met |-> (!ce_n && !we_n && oe_n));

    generate
        if (FILT > 1) begin : g_multi
            // R6: recognition needs the condition in the previous cycle too
            p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
                hold_met |-> $past(wr_active));
        end
    endgenerate

endmodule

// File: rtl/wrq_write_fsm.sv
module wrq_write_fsm
    import wrq_pkg::*;
#(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_active,
    input  logic          hold_met,
    input  logic          por_ready,
    input  logic          supply_low,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    wq_state_e state_q, state_d;
    logic [AW-1:0] addr_hold_q;
    logic [DW-1:0] data_hold_q;
    logic          enable;

    assign enable = por_ready && !supply_low;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WQ_IDLE: begin
                if (hold_met) begin
                    state_d = enable ? WQ_ARMED : WQ_REJECT;
                end
            end
            WQ_ARMED: begin
                if (supply_low) begin
                    state_d = WQ_REJECT;
                end else if (!wr_active) begin
                    state_d = WQ_ISSUE;
                end
            end
            WQ_REJECT: begin
                if (!wr_active) begin
                    state_d = WQ_IDLE;
                end
            end
            WQ_ISSUE: begin
                state_d = WQ_IDLE;
            end
            default: state_d = WQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold_q <= '0;
            data_hold_q <= '0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            if (wr_active) begin
                addr_hold_q <= addr_i;
                data_hold_q <= data_i;
            end
            if (state_q == WQ_ARMED && state_d == WQ_ISSUE) begin
                wr_addr <= addr_hold_q;
                wr_data <= data_hold_q;
            end
        end
    end

    assign wr_pulse = (state_q == WQ_ISSUE);

    // R7: the accepted-write pulse is exactly one cycle wide
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R7: a pulse follows a cycle in which the strobe had ended
    p_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(!wr_active));

    // R4: no pulse follows a low-supply cycle
    p_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(!supply_low));

    // R2: arming from IDLE needs an expired hold-off
    p_arm_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WQ_ARMED && $past(state_q) == WQ_IDLE) |-> $past(por_ready));

    // R8: captured address and data move only with the pulse
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

// File: rtl/wr_qualifier.sv
module wr_qualifier
    import wrq_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned POR_US    = 6000,
    parameter int unsigned GLITCH_NS = 20,
    parameter int unsigned AW        = 15,
    parameter int unsigned DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          supply_low,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int unsigned POR_CYCLES = wq_at_least_one(CLK_MHZ * POR_US);
    localparam int unsigned FILT = wq_at_least_one(wq_ceil_div(GLITCH_NS * CLK_MHZ, 1000));

    logic por_ready;
    logic wr_active;
    logic hold_met;

    wrq_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .por_ready  (por_ready)
    );

    wrq_strobe_filter #(.FILT(FILT)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .wr_active (wr_active),
        .hold_met  (hold_met)
    );

    wrq_write_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_active  (wr_active),
        .hold_met   (hold_met),
        .por_ready  (por_ready),
        .supply_low (supply_low),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .wr_pulse   (wr_pulse),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

endmodule

// File: tb/wr_qualifier_tb.sv
`timescale 1ns/1ps
module wr_qualifier_tb;
    localparam int unsigned AW = 15;
    localparam int unsigned DW = 8;
    localparam int unsigned POR = 100;   // 100 MHz * 1 us
    localparam int unsigned FILT = 3;    // ceil(30 ns * 100 MHz)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] data_i = '0;
    logic wr_pulse;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wr_qualifier #(.CLK_MHZ(100), .POR_US(1), .GLITCH_NS(30), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_low(supply_low), .addr_i(addr_i), .data_i(data_i),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) if (wr_pulse) pulses++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive pins for n cycles, release, check latency, count and captured data
    task automatic strobe(input logic c, input logic w, input logic o, input int n,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit exp, input string req);
        int base;
        base = pulses;
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; addr_i = a; data_i = d;
        idle(n);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr_i = ~a; data_i = ~d;
        @(negedge clk);
        chk(wr_pulse == exp, req, 32'(wr_pulse), 32'(exp));
        idle(4);
        #1;
        chk(pulses - base == int'(exp), req, 32'(pulses - base), 32'(exp));
        if (exp) begin
            chk(wr_addr == a, req, 32'(wr_addr), 32'(a));
            chk(wr_data == d, req, 32'(wr_data), 32'(d));
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(wr_pulse == 1'b0, "R1", 32'(wr_pulse), 0);
        chk(wr_addr == '0 && wr_data == '0, "R1", {wr_addr, wr_data}, 0);
    endtask

    task automatic t_power_on;
        strobe(0, 0, 1, 5, 15'h0011, 8'h11, 0, "R2 early");
        idle(POR);
        strobe(0, 0, 1, 5, 15'h1234, 8'h5A, 1, "R2 after hold-off R7 R8");
    endtask

    task automatic t_glitch;
        strobe(0, 0, 1, FILT - 1, 15'h0100, 8'h01, 0, "R6 short");
        strobe(0, 0, 1, 1, 15'h0101, 8'h02, 0, "R6 one cycle");
        strobe(0, 0, 1, FILT, 15'h0222, 8'h22, 1, "R6 minimum");
    endtask

    task automatic t_inhibit;
        strobe(0, 0, 0, 6, 15'h0300, 8'h30, 0, "R5 oe low");
        strobe(1, 0, 1, 6, 15'h0301, 8'h31, 0, "R5 ce high");
        strobe(0, 1, 1, 6, 15'h0302, 8'h32, 0, "R5 we high");
        // R8: outputs still hold the last accepted write
        chk(wr_addr == 15'h0222 && wr_data == 8'h22, "R8 hold", {wr_addr, wr_data}, {15'h0222, 8'h22});
    endtask

    task automatic t_addr_track;
        int base;
        base = pulses;
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr_i = 15'h0400; data_i = 8'h40;
        idle(3);
        addr_i = 15'h7ABC; data_i = 8'hC3;
        idle(2);
        ce_n = 1; we_n = 1; addr_i = 15'h0001; data_i = 8'h01;
        @(negedge clk);
        chk(wr_pulse == 1'b1, "R7 latency", 32'(wr_pulse), 1);
        @(negedge clk);
        chk(wr_pulse == 1'b0, "R7 width", 32'(wr_pulse), 0);
        chk(wr_addr == 15'h7ABC, "R8 last addr", 32'(wr_addr), 32'h7ABC);
        chk(wr_data == 8'hC3, "R8 last data", 32'(wr_data), 32'hC3);
        idle(3);
        #1;
        chk(pulses - base == 1, "R7 count", 32'(pulses - base), 1);
    endtask

    task automatic t_supply;
        @(negedge clk);
        supply_low = 1'b1;
        strobe(0, 0, 1, 6, 15'h0500, 8'h50, 0, "R4 supply low");
        supply_low = 1'b0;
        strobe(0, 0, 1, 6, 15'h0501, 8'h51, 0, "R3 restarted hold-off");
        idle(POR);
        strobe(0, 0, 1, 6, 15'h0502, 8'h52, 1, "R3 after restart");
    endtask

    task automatic t_discard;
        int base;
        base = pulses;
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr_i = 15'h0600; data_i = 8'h60;
        idle(FILT + 2);
        supply_low = 1'b1;
        @(negedge clk);
        supply_low = 1'b0;
        idle(2);
        ce_n = 1; we_n = 1;
        idle(5);
        #1;
        chk(pulses - base == 0, "R9 discard", 32'(pulses - base), 0);
        chk(wr_addr == 15'h0502, "R9 outputs kept", 32'(wr_addr), 32'h0502);
        idle(POR);
    endtask

    task automatic t_late_enable;
        int base;
        base = pulses;
        @(negedge clk);
        supply_low = 1'b1;
        ce_n = 0; we_n = 0; oe_n = 1; addr_i = 15'h0700; data_i = 8'h70;
        idle(FILT + 2);
        supply_low = 1'b0;
        idle(POR + 30);
        ce_n = 1; we_n = 1;
        idle(5);
        #1;
        chk(pulses - base == 0, "R10 late enable", 32'(pulses - base), 0);
        strobe(0, 0, 1, 4, 15'h0777, 8'h77, 1, "R10 next strobe");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_power_on();
        t_glitch();
        t_inhibit();
        t_addr_track();
        t_supply();
        t_discard();
        t_late_enable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule